// File: doc/BRIEF.md
# Frame-Sync Triggered Parallel Capture

This block samples a parallel data bus on the port clock. A rising edge on an external frame-sync input starts each capture. Once the edge is seen, the block waits a programmable number of port-clock cycles. It then takes a programmable number of consecutive samples, one per clock.

Each sample is masked to the selected data width and zero-filled to the full output word. It is then offered on a valid/ready stream. A single-cycle done pulse marks the last sample of the window, and the block then waits for the next frame sync. The downstream side must take each sample in the cycle it is offered. A sample that meets a low ready is dropped and raises a sticky overflow flag.

The port works in capture direction only. Transmit is never active at the same time as capture, so the block has no transmit path.

Top module: `fcap_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, out_valid, frame_done and overflow are all 0.
- R2: A frame starts only on a rising edge of fsync, meaning fsync is high at a clock edge after being low at the previous edge. Holding fsync high starts no further frames.
- R3: Let the detection edge be edge k and the delay setting be D. The first sample is taken at edge k+D+1, so D=0 samples on the very next edge. Each sample appears on out_data with out_valid high during the cycle that follows the edge at which it was taken.
- R4: A frame takes exactly N samples on N consecutive edges, where N is cfg_count at detection. A count of 0 is treated as 1.
- R5: The width code selects the sample width: code 0 selects 8 bits, and code c from 1 to 7 selects 9+c bits (10 to 16). Data bits above the selected width read 0 on out_data.
- R6: If out_ready is low at the edge where a sample is taken, that sample is dropped: out_valid stays 0 in the next cycle. The sample still counts toward the window. overflow goes to 1 and stays 1 until reset.
- R7: frame_done is high for exactly one cycle. That cycle is the one after the edge that took the last sample. The block then re-arms and accepts a new rising edge from that cycle on.
- R8: A rising edge of fsync during the delay wait or the capture window is ignored. It neither restarts nor extends the frame.
- R9: cfg_delay, cfg_count and cfg_width are sampled at the detection edge. Changing them later has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | External frame sync; a rising edge arms a capture |
| pdata | input | DATA_W | Parallel data bus |
| cfg_delay | input | DLY_W | Cycles between sync detection and the first sample |
| cfg_count | input | CNT_W | Samples per frame (0 acts as 1) |
| cfg_width | input | 3 | Width code: 0 selects 8 bits, c selects 9+c bits |
| out_ready | input | 1 | Downstream can accept a sample this cycle |
| out_data | output | DATA_W | Captured sample, zero-filled above the width |
| out_valid | output | 1 | out_data holds a new sample |
| frame_done | output | 1 | One-cycle pulse after the last sample of a frame |
| overflow | output | 1 | Sticky flag: a sample met a low out_ready |

## Verification
The bench builds the block with its default parameters: a 16-bit bus, an 8-bit delay counter and a 12-bit sample counter. With the 16-bit bus, every width code from 8 to 16 bits can be driven with random data, and zero fill can be seen on every upper bit. The small delays and counts used (0 to 5 cycles, 0 to 8 samples) keep each frame short. This leaves room to test back-to-back frames, a held sync level, a sync pulse in the middle of a frame, and configuration changes during a frame within one short run.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

    localparam int WCODE_W = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WAIT,
        SEQ_TAKE
    } seq_mode_e;

    // width code 0 -> 8 bits, code c (1..7) -> 9+c bits
    function automatic int lane_bits(input logic [WCODE_W-1:0] code);
        return (code == '0) ? 8 : 9 + int'(code);
    endfunction

endpackage

// File: rtl/fcap_edge.sv
module fcap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync_i,
    output logic rise_o
);

    typedef struct packed {
        logic fs;
    } edge_t;

    edge_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.fs = fsync_i;
        rise_o = fsync_i & ~r_q.fs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/fcap_lane_mask.sv
module fcap_lane_mask #(
    parameter int DATA_W = 16
) (
    input  logic [fcap_pkg::WCODE_W-1:0] wcode_i,
    output logic [DATA_W-1:0]            mask_o
);

    int lane_w;
    assign lane_w = fcap_pkg::lane_bits(wcode_i);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign mask_o[b] = (b < lane_w);
    end

endmodule

// File: rtl/fcap_seq.sv
module fcap_seq #(
    parameter int DLY_W = 8,
    parameter int CNT_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rise_i,
    input  logic [DLY_W-1:0]             cfg_delay_i,
    input  logic [CNT_W-1:0]             cfg_count_i,
    input  logic [fcap_pkg::WCODE_W-1:0] cfg_width_i,
    output logic                         take_o,
    output logic                         last_o,
    output logic [fcap_pkg::WCODE_W-1:0] wcode_o
);
    import fcap_pkg::*;

    typedef struct packed {
        seq_mode_e            mode;
        logic [DLY_W-1:0]     dly;
        logic [CNT_W-1:0]     cnt;
        logic [WCODE_W-1:0]   wcode;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        take_o = 1'b0;
        last_o = 1'b0;
        unique case (r_q.mode)
            SEQ_IDLE: begin
                if (rise_i) begin
                    r_d.wcode = cfg_width_i;
                    r_d.dly   = cfg_delay_i;
                    r_d.cnt   = (cfg_count_i == '0) ? CNT_W'(1) : cfg_count_i;
                    r_d.mode  = (cfg_delay_i == '0) ? SEQ_TAKE : SEQ_WAIT;
                end
            end
            SEQ_WAIT: begin
                r_d.dly = r_q.dly - DLY_W'(1);
                if (r_q.dly == DLY_W'(1)) r_d.mode = SEQ_TAKE;
            end
            SEQ_TAKE: begin
                take_o  = 1'b1;
                r_d.cnt = r_q.cnt - CNT_W'(1);
                if (r_q.cnt == CNT_W'(1)) begin
                    last_o   = 1'b1;
                    r_d.mode = SEQ_IDLE;
                end
            end
            default: r_d.mode = SEQ_IDLE;
        endcase
    end

    assign wcode_o = r_q.wcode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mode <= SEQ_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R3: a wait phase always has cycles left to count
    assert_wait_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == SEQ_WAIT) |-> (r_q.dly != '0));

    // R4: the capture window never runs on an empty count
    assert_take_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == SEQ_TAKE) |-> (r_q.cnt != '0));

    // R9: latched width stays put while a frame is in flight
    assert_width_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode != SEQ_IDLE) |=> $stable(r_q.wcode) || ($past(r_q.mode) == SEQ_IDLE));

endmodule

// File: rtl/fcap_top.sv
module fcap_top #(
    parameter int DATA_W = 16,
    parameter int DLY_W  = 8,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [DATA_W-1:0] pdata,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [2:0]        cfg_width,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              frame_done,
    output logic              overflow
);
    import fcap_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              done;
        logic              ovf;
    } out_t;

    logic               rise;
    logic               take;
    logic               last;
    logic [WCODE_W-1:0] wcode;
    logic [DATA_W-1:0]  lane_mask;
    out_t               o_q, o_d;

    fcap_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync_i (fsync),
        .rise_o  (rise)
    );

    fcap_seq #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .cfg_delay_i (cfg_delay),
        .cfg_count_i (cfg_count),
        .cfg_width_i (cfg_width),
        .take_o      (take),
        .last_o      (last),
        .wcode_o     (wcode)
    );

    fcap_lane_mask #(.DATA_W(DATA_W)) u_mask (
        .wcode_i (wcode),
        .mask_o  (lane_mask)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = take & out_ready;
        o_d.done  = last;
        o_d.ovf   = o_q.ovf | (take & ~out_ready);
        if (take & out_ready) o_d.data = pdata & lane_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_data   = o_q.data;
    assign out_valid  = o_q.valid;
    assign frame_done = o_q.done;
    assign overflow   = o_q.ovf;

    // R3: a valid output only follows a capture edge
    assert_valid_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(take));

    // R5: nothing above the selected width leaks out
    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & ~lane_mask) == '0));

    // R6: overflow is sticky
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R7: done lasts one cycle
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R7: done only after a capture edge
    assert_done_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(take));

endmodule

// File: tb/sim_fcap_top.sv
module sim_fcap_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic [15:0] pdata = '0;
    logic [7:0]  cfg_delay = '0;
    logic [11:0] cfg_count = '0;
    logic [2:0]  cfg_width = '0;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;
    logic        out_valid, frame_done, overflow;

    always #2 clk = ~clk;

    fcap_top u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .pdata(pdata),
        .cfg_delay(cfg_delay), .cfg_count(cfg_count), .cfg_width(cfg_width),
        .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid),
        .frame_done(frame_done), .overflow(overflow)
    );

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    int    nvalid = 0;
    int    ndone = 0;
    int    cycles = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lane(input int code);
        int w = (code == 0) ? 8 : 9 + code;
        return 16'((32'h1 << w) - 1);
    endfunction

    // behavioural reference: 0 idle, 1 waiting, 2 sampling
    int          m_mode = 0;
    int          m_dly = 0;
    int          m_cnt = 0;
    int          m_code = 0;
    bit          m_prev = 0;
    bit          e_valid = 0;
    bit          e_done = 0;
    bit          e_ovf = 0;
    logic [15:0] e_data = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_prev = 0; e_valid = 0; e_done = 0; e_ovf = 0;
        end else begin
            bit rise_now;
            rise_now = fsync && !m_prev;
            m_prev   = fsync;
            e_valid  = 0;
            e_done   = 0;
            if (m_mode == 0) begin
                if (rise_now) begin
                    m_code = int'(cfg_width);
                    m_cnt  = (cfg_count == 0) ? 1 : int'(cfg_count);
                    m_dly  = int'(cfg_delay);
                    m_mode = (m_dly == 0) ? 2 : 1;
                end
            end else if (m_mode == 1) begin
                m_dly--;
                if (m_dly == 0) m_mode = 2;
            end else begin
                if (out_ready) begin
                    e_valid = 1;
                    e_data  = pdata & lane(m_code);
                end else begin
                    e_ovf = 1;
                end
                m_cnt--;
                if (m_cnt == 0) begin
                    e_done = 1;
                    m_mode = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, {31'd0, out_valid}, {31'd0, e_valid});
            chk(cur_req, {31'd0, frame_done}, {31'd0, e_done});
            chk(cur_req, {31'd0, overflow}, {31'd0, e_ovf});
            if (e_valid) chk(cur_req, {16'd0, out_data}, {16'd0, e_data});
            if (out_valid) nvalid++;
            if (frame_done) ndone++;
        end
    end

    always @(negedge clk) pdata <= 16'($urandom);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // one frame; pulse_at >= 0 gives an extra sync pulse, hold keeps sync high,
    // mid changes the configuration one cycle after the sync
    task automatic frame(input int d, input int n, input int w, input string req,
                         input int pulse_at, input bit hold, input bit mid,
                         input bit rdy, input int exp_valid);
        @(posedge clk);
        cur_req = req;
        nvalid = 0;
        ndone = 0;
        @(negedge clk);
        cfg_delay = 8'(d);
        cfg_count = 12'(n);
        cfg_width = 3'(w);
        out_ready = rdy;
        fsync = 1'b1;
        for (int i = 0; i < d + n + 5; i++) begin
            @(negedge clk);
            fsync = hold ? 1'b1 : (i == pulse_at);
            if (mid && i == 1) begin
                cfg_delay = 8'd0;
                cfg_count = 12'd2;
                cfg_width = 3'd0;
            end
        end
        fsync = 1'b0;
        out_ready = 1'b1;
        @(posedge clk);
        chk(req, nvalid, exp_valid);
        chk(req, ndone, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {29'd0, out_valid, frame_done, overflow}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {29'd0, out_valid, frame_done, overflow}, 32'd0);

        frame(3, 5, 7, "R3", -1, 0, 0, 1, 5);   // 16-bit, delay 3
        frame(0, 1, 0, "R3", -1, 0, 0, 1, 1);   // zero delay, 8-bit
        frame(2, 4, 1, "R5", -1, 0, 0, 1, 4);   // 10-bit lanes
        frame(1, 6, 4, "R5", -1, 0, 0, 1, 6);   // 13-bit lanes
        frame(0, 3, 6, "R5", -1, 0, 0, 1, 3);   // 15-bit lanes
        frame(2, 0, 7, "R4", -1, 0, 0, 1, 1);   // count 0 acts as 1
        frame(0, 8, 2, "R4", -1, 0, 0, 1, 8);
        frame(1, 4, 3, "R2", -1, 1, 0, 1, 4);   // level held high
        frame(1, 8, 5, "R8", 4, 0, 0, 1, 8);    // pulse inside window
        frame(5, 3, 7, "R8", 2, 0, 0, 1, 3);    // pulse during wait
        frame(4, 5, 2, "R9", -1, 0, 1, 1, 5);   // config changes mid-frame
        frame(0, 2, 0, "R7", -1, 0, 0, 1, 2);
        frame(0, 2, 0, "R7", -1, 0, 0, 1, 2);   // re-armed after done

        chk("R6", {31'd0, overflow}, 32'd0);
        frame(1, 3, 7, "R6", -1, 0, 0, 0, 0);   // ready low: all dropped
        chk("R6", {31'd0, overflow}, 32'd1);
        frame(0, 4, 7, "R6", -1, 0, 0, 1, 4);   // flag stays set
        chk("R6", {31'd0, overflow}, 32'd1);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule